// File: doc/BRIEF.md
# Watchdog Critical Interrupt Entry Unit

This block turns a pending watchdog condition into a critical-class interrupt and applies the state changes that go with entering and leaving the handler. A one-cycle event pulse from an external timer sets a sticky status bit. While that bit is set, the timer-control enable is on, the critical-enable bit of the machine-state register is on and nothing of higher priority is pending, the block raises a take pulse. In the same cycle it presents the handler's fetch address.

On the clock edge of a take, the block saves the next-instruction address and the old machine-state word into two dedicated critical save registers. It then clears the machine-state register except for its machine-check-enable bit. A return strobe restores the machine-state word from the second save register and redirects fetch to the address held in the first. Software sets the machine-state word through a load port. It clears the status bit with a write-one-to-clear mask. The critical-enable bit is exported so that a second critical source can be gated by the same bit.

Top module: `wdog_crit_entry`

## Requirements
- R1: `take_o` is 1 exactly when status bit 30 is 1, `wd_irq_en_i` is 1, machine-state bit 17 (critical enable) is 1 and `hi_pri_pend_i` is 0.
- R2: `crit_en_o` always equals machine-state bit 17.
- R3: On the edge where `take_o` is 1, `csrr0_o` is loaded with `next_pc_i`.
- R4: On the edge where `take_o` is 1, `csrr1_o` is loaded with the whole machine-state word held before that edge.
- R5: After a take, machine-state bit 12 (machine-check enable) keeps its value and every other machine-state bit is 0.
- R6: While `take_o` is 1, `pc_o` equals `{vec_prefix_i[15:0], vec_offset_i[11:0], 4'b0000}` and `redirect_o` is 1.
- R7: A status write (`stat_wr_i`) clears each status bit whose mask bit is 1 and leaves each bit whose mask bit is 0 unchanged.
- R8: The status bit 30, once set by `wd_event_i`, stays set until cleared by a write, so re-enabling bit 17 before clearing it yields another take.
- R9: When `wd_event_i` and a status write with mask bit 30 set occur in the same cycle, status bit 30 ends up 1.
- R10: `take_o` is never 1 in two consecutive cycles.
- R11: When `rfci_i` is 1 and `take_o` is 0, `pc_o` equals `csrr0_o`, `redirect_o` is 1, and on that edge the machine-state word is reloaded from `csrr1_o`. When both are 1, the take wins.
- R12: After reset the machine-state word, status word and both save registers are 0, and `take_o` and `redirect_o` are 0.
- R13: `msr_wr_i` loads `msr_wdata_i` into the machine-state word, except on a take edge, where the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_event_i | input | 1 | One-cycle watchdog event pulse |
| wd_irq_en_i | input | 1 | Watchdog interrupt enable from timer control |
| hi_pri_pend_i | input | 1 | A higher-priority exception is pending |
| next_pc_i | input | 32 | Address of the next instruction to execute |
| vec_prefix_i | input | 16 | Upper field of the vector prefix register |
| vec_offset_i | input | 12 | Watchdog vector offset field |
| msr_wr_i | input | 1 | Machine-state load strobe |
| msr_wdata_i | input | 32 | Machine-state load data |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 32 | Status write mask, ones clear |
| rfci_i | input | 1 | Return-from-critical-interrupt strobe |
| take_o | output | 1 | Interrupt taken this cycle |
| redirect_o | output | 1 | `pc_o` is valid this cycle |
| pc_o | output | 32 | New fetch address |
| csrr0_o | output | 32 | Critical save register 0 (return address) |
| csrr1_o | output | 32 | Critical save register 1 (saved machine-state) |
| msr_o | output | 32 | Machine-state register |
| tsr_o | output | 32 | Timer status register |
| crit_en_o | output | 1 | Critical-enable bit for other critical sources |

## Verification
The bench walks all sixteen combinations of the four take conditions. A design that drops one term of the AND would fire with that term low. Sticky status is probed by re-enabling critical enable with the bit still set: a design that cleared the bit on entry would not take again. An event that lands in the same cycle as a clearing write must leave the bit set, where a clear-wins design would lose an event. A return and a take arriving together must take the vector and keep only machine-check enable, where a return-wins design would fetch from the save register. A machine-state write on a take edge must be dropped, where a design that gave the write priority would leave critical enable on.

// File: rtl/wdog_crit_pkg.sv
package wdog_crit_pkg;
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ENTRY  = 2'd1,
    RD_RETURN = 2'd2
  } redirect_e;
endpackage

// File: rtl/wdog_stat_reg.sv
module wdog_stat_reg #(
  parameter int DW      = 32,
  parameter int WIS_BIT = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wmask_i,
  output logic [DW-1:0] tsr_o,
  output logic          wis_o
);
  logic [DW-1:0] tsr_q, set_vec, clr_vec;

  // only the watchdog bit has a hardware set source
  always_comb begin
    set_vec = '0;
    set_vec[WIS_BIT] = set_i;
    clr_vec = wr_i ? wmask_i : '0;
  end

  // set dominates a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tsr_q <= '0;
    else         tsr_q <= (tsr_q & ~clr_vec) | set_vec;
  end

  assign tsr_o = tsr_q;
  assign wis_o = tsr_q[WIS_BIT];

  // R9
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> wis_o);
  // R7
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wmask_i[WIS_BIT] && !set_i) |=> !wis_o);
  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !(wr_i && wmask_i[WIS_BIT])) |=> $stable(wis_o));
endmodule

// File: rtl/wdog_vec_gen.sv
module wdog_vec_gen #(
  parameter int DW    = 32,
  parameter int PFX_W = 16,
  parameter int OFF_W = 12
) (
  input  logic [PFX_W-1:0] prefix_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [DW-1:0]    vec_o
);
  localparam int ALIGN_W = DW - PFX_W - OFF_W;

  assign vec_o = {prefix_i, offset_i, {ALIGN_W{1'b0}}};

  // R6
  always_comb begin
    vec_align_chk: assert (vec_o[ALIGN_W-1:0] == '0);
  end
endmodule

// File: rtl/wdog_crit_state.sv
module wdog_crit_state #(
  parameter int DW     = 32,
  parameter int CE_BIT = 17,
  parameter int ME_BIT = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          take_i,
  input  logic          rfci_i,
  input  logic          msr_wr_i,
  input  logic [DW-1:0] msr_wdata_i,
  input  logic [DW-1:0] next_pc_i,
  output logic [DW-1:0] msr_o,
  output logic [DW-1:0] csrr0_o,
  output logic [DW-1:0] csrr1_o
);
  localparam logic [DW-1:0] KEEP_MASK = {{(DW-1){1'b0}}, 1'b1} << ME_BIT;

  logic [DW-1:0] msr_q, csrr0_q, csrr1_q;

  // entry > return > software load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q   <= '0;
      csrr0_q <= '0;
      csrr1_q <= '0;
    end else if (take_i) begin
      csrr0_q <= next_pc_i;
      csrr1_q <= msr_q;
      msr_q   <= msr_q & KEEP_MASK;
    end else if (rfci_i) begin
      msr_q   <= csrr1_q;
    end else if (msr_wr_i) begin
      msr_q   <= msr_wdata_i;
    end
  end

  assign msr_o   = msr_q;
  assign csrr0_o = csrr0_q;
  assign csrr1_o = csrr1_q;

  // R3
  save_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> csrr0_o == $past(next_pc_i));
  // R4
  save_msr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> csrr1_o == $past(msr_o));
  // R5
  entry_msr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (!msr_o[CE_BIT] && msr_o[ME_BIT] == $past(msr_o[ME_BIT])
                && $countones(msr_o) <= 1));
  // R11
  restore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfci_i && !take_i) |=> msr_o == $past(csrr1_o));
  // R13
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_wr_i && !take_i && !rfci_i) |=> msr_o == $past(msr_wdata_i));
endmodule

// File: rtl/wdog_crit_entry.sv
module wdog_crit_entry
  import wdog_crit_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CE_BIT  = 17,
  parameter int ME_BIT  = 12,
  parameter int WIS_BIT = 30,
  parameter int PFX_W   = 16,
  parameter int OFF_W   = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wd_event_i,
  input  logic             wd_irq_en_i,
  input  logic             hi_pri_pend_i,
  input  logic [DW-1:0]    next_pc_i,
  input  logic [PFX_W-1:0] vec_prefix_i,
  input  logic [OFF_W-1:0] vec_offset_i,
  input  logic             msr_wr_i,
  input  logic [DW-1:0]    msr_wdata_i,
  input  logic             stat_wr_i,
  input  logic [DW-1:0]    stat_wdata_i,
  input  logic             rfci_i,
  output logic             take_o,
  output logic             redirect_o,
  output logic [DW-1:0]    pc_o,
  output logic [DW-1:0]    csrr0_o,
  output logic [DW-1:0]    csrr1_o,
  output logic [DW-1:0]    msr_o,
  output logic [DW-1:0]    tsr_o,
  output logic             crit_en_o
);
  logic          wis;
  logic [DW-1:0] vec;
  redirect_e     cause;

  wdog_stat_reg #(.DW(DW), .WIS_BIT(WIS_BIT)) u_stat (
    .clk_i, .rst_ni,
    .set_i   (wd_event_i),
    .wr_i    (stat_wr_i),
    .wmask_i (stat_wdata_i),
    .tsr_o   (tsr_o),
    .wis_o   (wis)
  );

  wdog_vec_gen #(.DW(DW), .PFX_W(PFX_W), .OFF_W(OFF_W)) u_vec (
    .prefix_i (vec_prefix_i),
    .offset_i (vec_offset_i),
    .vec_o    (vec)
  );

  wdog_crit_state #(.DW(DW), .CE_BIT(CE_BIT), .ME_BIT(ME_BIT)) u_state (
    .clk_i, .rst_ni,
    .take_i      (take_o),
    .rfci_i      (rfci_i),
    .msr_wr_i    (msr_wr_i),
    .msr_wdata_i (msr_wdata_i),
    .next_pc_i   (next_pc_i),
    .msr_o       (msr_o),
    .csrr0_o     (csrr0_o),
    .csrr1_o     (csrr1_o)
  );

  assign crit_en_o = msr_o[CE_BIT];
  assign take_o    = wis & wd_irq_en_i & crit_en_o & ~hi_pri_pend_i;

  always_comb begin
    if (take_o)      cause = RD_ENTRY;
    else if (rfci_i) cause = RD_RETURN;
    else             cause = RD_NONE;
  end

  always_comb begin
    unique case (cause)
      RD_ENTRY:  pc_o = vec;
      RD_RETURN: pc_o = csrr0_o;
      default:   pc_o = '0;
    endcase
  end

  assign redirect_o = (cause != RD_NONE);

  // R10
  single_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  // R1
  take_needs_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> tsr_o[WIS_BIT]);
  // R11
  return_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfci_i && !take_o) |-> (redirect_o && pc_o == csrr0_o));
endmodule

// File: tb/wdog_crit_entry_test.sv
module wdog_crit_entry_test;
  localparam int CLK_PERIOD = 10;
  localparam int CE = 17;
  localparam int ME = 12;
  localparam int WS = 30;

  logic clk = 0;
  logic rst_ni = 0;
  logic wd_event = 0, wd_en = 0, hipri = 0, msr_wr = 0, stat_wr = 0, rfci = 0;
  logic [31:0] npc = '0, msr_wd = '0, stat_wd = '0;
  logic [15:0] vpfx = '0;
  logic [11:0] voff = '0;
  logic take, redir, crit_en;
  logic [31:0] pc, csrr0, csrr1, msr, tsr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_crit_entry uut (
    .clk_i(clk), .rst_ni(rst_ni), .wd_event_i(wd_event), .wd_irq_en_i(wd_en),
    .hi_pri_pend_i(hipri), .next_pc_i(npc), .vec_prefix_i(vpfx), .vec_offset_i(voff),
    .msr_wr_i(msr_wr), .msr_wdata_i(msr_wd), .stat_wr_i(stat_wr), .stat_wdata_i(stat_wd),
    .rfci_i(rfci), .take_o(take), .redirect_o(redir), .pc_o(pc), .csrr0_o(csrr0),
    .csrr1_o(csrr1), .msr_o(msr), .tsr_o(tsr), .crit_en_o(crit_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_ni = 0; wd_event = 0; wd_en = 0; hipri = 0; msr_wr = 0; stat_wr = 0; rfci = 0;
    npc = '0; msr_wd = '0; stat_wd = '0; vpfx = '0; voff = '0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic set_msr(input logic [31:0] v);
    msr_wr = 1; msr_wd = v; tick(); msr_wr = 0;
  endtask

  task automatic pulse_ev();
    wd_event = 1; tick(); wd_event = 0;
  endtask

  task automatic clr_stat(input logic [31:0] m);
    stat_wr = 1; stat_wd = m; tick(); stat_wr = 0;
  endtask

  function automatic logic [31:0] vexp(input logic [15:0] p, input logic [11:0] o);
    return {p, o, 4'b0000};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] mv, m0;
    // R12 reset state
    do_reset();
    #1;
    chk("R12 msr", msr, 32'h0);
    chk("R12 tsr", tsr, 32'h0);
    chk("R12 csrr0", csrr0, 32'h0);
    chk("R12 csrr1", csrr1, 32'h0);
    chk("R12 take", {31'b0, take}, 32'h0);
    chk("R12 redirect", {31'b0, redir}, 32'h0);

    // R1 exhaustive sweep of take conditions
    for (int i = 0; i < 16; i++) begin
      logic w, e, c, h, exp_t;
      w = i[0]; e = i[1]; c = i[2]; h = i[3];
      exp_t = w & e & c & ~h;
      do_reset();
      mv = (32'(c) << CE) | (32'h1 << ME) | 32'h0000_0101 | (32'(i) << 24);
      set_msr(mv);
      chk("R2", {31'b0, crit_en}, {31'b0, c});
      if (w) pulse_ev();
      wd_en = e; hipri = h;
      npc = 32'h1000_0000 + 32'(i) * 32'h10;
      vpfx = 16'hC000 | 16'(i); voff = 12'h0A0 + 12'(i);
      #1;
      chk("R1", {31'b0, take}, {31'b0, exp_t});
      chk("R6 redirect", {31'b0, redir}, {31'b0, exp_t});
      if (exp_t) begin
        chk("R6 vector", pc, vexp(vpfx, voff));
        tick();
        chk("R3", csrr0, npc);
        chk("R4", csrr1, mv);
        chk("R5", msr, 32'h1 << ME);
        chk("R10", {31'b0, take}, 32'h0);
        chk("R2 after entry", {31'b0, crit_en}, 32'h0);
      end
    end

    // R6 vector patterns
    for (int k = 0; k < 8; k++) begin
      do_reset();
      set_msr(32'h1 << CE);
      pulse_ev();
      wd_en = 1;
      vpfx = 16'h1234 ^ 16'(k * 16'h9E37);
      voff = 12'hFFF >> k;
      #1;
      chk("R6 pattern", pc, vexp(vpfx, voff));
      tick();
      chk("R5 ME clear kept", msr, 32'h0);
    end

    // R7 / R8 / R9 status behaviour, critical enable off
    do_reset();
    pulse_ev();
    chk("R8 set", tsr, 32'h1 << WS);
    clr_stat(32'h0);
    chk("R7 zero mask", tsr, 32'h1 << WS);
    clr_stat(~(32'h1 << WS));
    chk("R7 other bits", tsr, 32'h1 << WS);
    repeat (5) tick();
    chk("R8 sticky", tsr, 32'h1 << WS);
    wd_event = 1; stat_wr = 1; stat_wd = 32'h1 << WS; tick();
    wd_event = 0; stat_wr = 0;
    chk("R9 set wins", tsr, 32'h1 << WS);
    clr_stat(32'h1 << WS);
    chk("R7 clear", tsr, 32'h0);
    clr_stat(32'hFFFF_FFFF);
    chk("R7 clear idle", tsr, 32'h0);

    // R8 re-trigger, R13 write dropped on take
    do_reset();
    set_msr((32'h1 << CE) | (32'h1 << ME));
    pulse_ev();
    wd_en = 1; #1;
    chk("R1 first take", {31'b0, take}, 32'h1);
    msr_wr = 1; msr_wd = 32'hFFFF_FFFF; tick(); msr_wr = 0;
    chk("R13 write ignored on take", msr, 32'h1 << ME);
    chk("R8 status kept", tsr, 32'h1 << WS);
    set_msr((32'h1 << CE) | (32'h1 << ME));
    #1;
    chk("R8 retrigger", {31'b0, take}, 32'h1);
    tick();
    clr_stat(32'h1 << WS);
    set_msr(32'h1 << CE);
    #1;
    chk("R13 load", msr, 32'h1 << CE);
    chk("R8 no take after clear", {31'b0, take}, 32'h0);

    // R11 return
    do_reset();
    m0 = (32'h1 << CE) | (32'h1 << ME) | 32'h0000_00F0;
    set_msr(m0);
    pulse_ev();
    wd_en = 1; npc = 32'hABCD_0120; tick();
    clr_stat(32'h1 << WS);
    rfci = 1; #1;
    chk("R11 pc", pc, 32'hABCD_0120);
    chk("R11 redirect", {31'b0, redir}, 32'h1);
    chk("R11 no take", {31'b0, take}, 32'h0);
    tick(); rfci = 0;
    chk("R11 msr restore", msr, m0);
    chk("R2 restored", {31'b0, crit_en}, 32'h1);

    // R11 take wins over return
    do_reset();
    set_msr((32'h1 << CE) | (32'h1 << ME));
    pulse_ev();
    wd_en = 1; rfci = 1; vpfx = 16'h00FF; voff = 12'h123; npc = 32'h0000_4444; #1;
    chk("R11 take priority pc", pc, vexp(16'h00FF, 12'h123));
    tick(); rfci = 0;
    chk("R11 take priority msr", msr, 32'h1 << ME);
    chk("R3 priority save", csrr0, 32'h0000_4444);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule